// File: doc/BRIEF.md
# Fall-Through Byte Queue with Handshake and Level Flags

This block is a single-clock first-in first-out byte store, 8 bits wide and 32 entries deep. Its read port works in fall-through fashion: whenever the queue holds data, the oldest byte is already present on the read data output. Asserting the read enable consumes that byte, and the next byte appears on the following cycle. No request has to be issued ahead of the data.

Both sides report their state every cycle. The write side shows full, almost-full, a one-cycle acknowledge for each accepted write, a one-cycle overflow pulse for each write attempted while full, and an occupancy count. The read side shows empty, almost-empty, a valid level, a one-cycle underflow pulse for each read attempted while empty, and its own occupancy count. A surrounding controller can start a burst transfer once the count reaches a chosen level, such as 15. It can then drain the queue until empty rises.

A synchronous active-high reset returns the block to empty.

Top module: `fwft_fifo`

## Requirements
- R1: In the cycle after a clock edge with reset high, the outputs are: empty=1, full=0, almost_full=0, almost_empty=0, rd_valid=0, wr_ack=0, overflow=0, underflow=0, and both counts are 0.
- R2: Bytes leave in the order they were accepted. Up to 32 bytes can be held at once.
- R3: After a byte is written into an empty queue, the next cycle shows empty=0 and rd_valid=1, with that byte on rd_data.
- R4: A read accepted while the queue holds two or more bytes puts the next-oldest byte on rd_data in the following cycle.
- R5: full is 1 exactly when 32 bytes are held, and empty is 1 exactly when none are held. wr_count and rd_count both equal the occupancy modulo 32, so they read 0 when the queue is full.
- R6: almost_full is 1 exactly when 31 bytes are held. almost_empty is 1 exactly when 1 byte is held.
- R7: wr_ack is 1 in the cycle after a write accepted while not full, and 0 otherwise.
- R8: A write attempted while full is discarded and overflow is 1 in the next cycle. The held bytes and their order do not change.
- R9: A read attempted while empty has no effect, and underflow is 1 in the next cycle.
- R10: When the queue is neither empty nor full, a read and a write in the same cycle both succeed and the occupancy stays the same. When it is full, the read succeeds and the write is rejected with overflow. When it is empty, the write succeeds and the read is rejected with underflow.
- R11: rd_valid is 1 exactly in the cycles where at least one byte is held, meaning rd_data carries a stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | 8 | Byte to store |
| wr_en | input | 1 | Write request |
| full | output | 1 | 32 bytes held |
| almost_full | output | 1 | 31 bytes held |
| wr_ack | output | 1 | Previous cycle's write was accepted |
| overflow | output | 1 | Previous cycle's write was rejected |
| wr_count | output | 5 | Occupancy modulo 32, write side |
| rd_data | output | 8 | Oldest held byte |
| rd_en | input | 1 | Read request, consumes rd_data |
| empty | output | 1 | No bytes held |
| almost_empty | output | 1 | 1 byte held |
| rd_valid | output | 1 | rd_data holds a stored byte |
| underflow | output | 1 | Previous cycle's read was rejected |
| rd_count | output | 5 | Occupancy modulo 32, read side |

## Verification
A pointer that drifts from the occupancy shows up on rd_data as a wrong or repeated byte in the very next cycle that data is valid. The reference queue in the bench catches it at that cycle. An occupancy error changes the empty, full, almost flags or counts in the cycle after the bad update, and the bench compares these every cycle. A handshake pulse that is wrongly gated, for example a write that is accepted while full, shows up one cycle later in wr_ack or overflow. It also shows up as a byte out of order when the queue drains.

// File: rtl/fwft_pkg.sv
package fwft_pkg;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 32;
    localparam int AW     = $clog2(DEPTH);
    localparam int OW     = AW + 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [AW-1:0]     ptr_t;
    typedef logic [OW-1:0]     occ_t;

    // Decision for one cycle: what is taken, what is turned away
    typedef struct packed {
        logic wr_take;
        logic rd_take;
        logic wr_drop;
        logic rd_drop;
    } xfer_t;

    // Registered one-cycle handshake pulses
    typedef struct packed {
        logic ack;
        logic ovf;
        logic unf;
    } pulse_t;

    function automatic ptr_t ptr_step(ptr_t p);
        return (p == ptr_t'(DEPTH - 1)) ? '0 : ptr_t'(p + 1'b1);
    endfunction
endpackage

// File: rtl/fwft_store.sv
module fwft_store
    import fwft_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  ptr_t  waddr,
    input  byte_t wdata,
    input  ptr_t  raddr,
    output byte_t rdata
);
    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Fall-through: head cell is read combinationally
    assign rdata = cells[raddr];
endmodule

// File: rtl/fwft_ctrl.sv
module fwft_ctrl
    import fwft_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  rd_en,
    output xfer_t xf,
    output ptr_t  wptr,
    output ptr_t  rptr,
    output occ_t  occ
);
    logic is_full, is_empty;

    always_comb begin
        is_full    = (occ == occ_t'(DEPTH));
        is_empty   = (occ == '0);
        xf.rd_take = rd_en && !is_empty;
        xf.rd_drop = rd_en && is_empty;
        xf.wr_take = wr_en && !is_full;
        xf.wr_drop = wr_en && is_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (xf.wr_take) wptr <= ptr_step(wptr);
            if (xf.rd_take) rptr <= ptr_step(rptr);
            occ <= occ + occ_t'(xf.wr_take) - occ_t'(xf.rd_take);
        end
    end
endmodule

// File: rtl/fwft_flags.sv
module fwft_flags
    import fwft_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  xfer_t  xf,
    input  occ_t   occ,
    output pulse_t pulse,
    output logic   lvl_full,
    output logic   lvl_empty,
    output logic   lvl_afull,
    output logic   lvl_aempty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= '0;
        end else begin
            pulse.ack <= xf.wr_take;
            pulse.ovf <= xf.wr_drop;
            pulse.unf <= xf.rd_drop;
        end
    end

    always_comb begin
        lvl_full   = (occ == occ_t'(DEPTH));
        lvl_empty  = (occ == '0);
        lvl_afull  = (occ == occ_t'(DEPTH - 1));
        lvl_aempty = (occ == occ_t'(1));
    end
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo
    import fwft_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    wr_data,
    input  logic          wr_en,
    output logic          full,
    output logic          almost_full,
    output logic          wr_ack,
    output logic          overflow,
    output logic [4:0]    wr_count,
    output logic [7:0]    rd_data,
    input  logic          rd_en,
    output logic          empty,
    output logic          almost_empty,
    output logic          rd_valid,
    output logic          underflow,
    output logic [4:0]    rd_count
);
    xfer_t  xf;
    ptr_t   wptr, rptr;
    occ_t   occ;
    pulse_t pulse;
    byte_t  head;

    fwft_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .xf   (xf),
        .wptr (wptr),
        .rptr (rptr),
        .occ  (occ)
    );

    fwft_store u_store (
        .clk  (clk),
        .we   (xf.wr_take),
        .waddr(wptr),
        .wdata(wr_data),
        .raddr(rptr),
        .rdata(head)
    );

    fwft_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .xf        (xf),
        .occ       (occ),
        .pulse     (pulse),
        .lvl_full  (full),
        .lvl_empty (empty),
        .lvl_afull (almost_full),
        .lvl_aempty(almost_empty)
    );

    assign rd_data   = head;
    assign rd_valid  = !empty;
    assign wr_ack    = pulse.ack;
    assign overflow  = pulse.ovf;
    assign underflow = pulse.unf;
    assign wr_count  = occ[AW-1:0];
    assign rd_count  = occ[AW-1:0];
endmodule

// File: rtl/fwft_fifo_chk.sv
module fwft_fifo_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] wr_data,
    input logic       wr_en,
    input logic       rd_en,
    input logic       full,
    input logic       empty,
    input logic       wr_ack,
    input logic       overflow,
    input logic       underflow,
    input logic       rd_valid,
    input logic [7:0] rd_data
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (empty && !full && !wr_ack && !overflow && !underflow));

    p_fall_through_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && empty && !rd_en) |=> (rd_valid && rd_data == $past(wr_data)));

    p_ack_on_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full) |=> wr_ack);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> (overflow && !wr_ack));

    p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_en) |=> (full && $stable(rd_data)));

    p_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> underflow);

    p_empty_stays_r9: assert property (@(posedge clk) disable iff (rst)
        (empty && !wr_en) |=> empty);

    p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
endmodule

bind fwft_fifo fwft_fifo_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .full     (full),
    .empty    (empty),
    .wr_ack   (wr_ack),
    .overflow (overflow),
    .underflow(underflow),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/fwft_fifo_bench.sv
module fwft_fifo_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       full, almost_full, wr_ack, overflow;
    logic       empty, almost_empty, rd_valid, underflow;
    logic [4:0] wr_count, rd_count;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model
    logic [7:0] q[$];
    bit m_ack, m_ovf, m_unf;

    always #4 clk = ~clk;

    fwft_fifo u_fwft_fifo (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en),
        .full(full), .almost_full(almost_full), .wr_ack(wr_ack),
        .overflow(overflow), .wr_count(wr_count), .rd_data(rd_data),
        .rd_en(rd_en), .empty(empty), .almost_empty(almost_empty),
        .rd_valid(rd_valid), .underflow(underflow), .rd_count(rd_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int n = q.size();
        chk(empty == (n == 0),        "R5 empty",        int'(empty),        int'(n == 0));
        chk(full == (n == 32),        "R5 full",         int'(full),         int'(n == 32));
        chk(wr_count == 5'(n),        "R5 wr_count",     int'(wr_count),     n % 32);
        chk(rd_count == 5'(n),        "R5 rd_count",     int'(rd_count),     n % 32);
        chk(almost_full == (n == 31), "R6 almost_full",  int'(almost_full),  int'(n == 31));
        chk(almost_empty == (n == 1), "R6 almost_empty", int'(almost_empty), int'(n == 1));
        chk(rd_valid == (n != 0),     "R11 rd_valid",    int'(rd_valid),     int'(n != 0));
        chk(wr_ack == m_ack,          "R7 wr_ack",       int'(wr_ack),       int'(m_ack));
        chk(overflow == m_ovf,        "R8 overflow",     int'(overflow),     int'(m_ovf));
        chk(underflow == m_unf,       "R9 underflow",    int'(underflow),    int'(m_unf));
        if (n != 0)
            chk(rd_data == q[0], "R2 R3 R4 rd_data order", int'(rd_data), int'(q[0]));
    endtask

    // One clock: drive at falling edge, update model at rising edge, compare 1 ns later
    task automatic step(input bit r, input bit we, input logic [7:0] d, input bit re);
        @(negedge clk);
        rst = r; wr_en = we; wr_data = d; rd_en = re;
        @(posedge clk);
        if (r) begin
            q.delete();
            m_ack = 0; m_ovf = 0; m_unf = 0;
        end else begin
            int n = q.size();
            bit wtake = we && (n < 32);
            bit rtake = re && (n > 0);
            m_ack = wtake;
            m_ovf = we && (n == 32);
            m_unf = re && (n == 0);
            if (rtake) void'(q.pop_front());
            if (wtake) q.push_back(d);
        end
        #1;
        compare_all();
    endtask

    initial begin
        logic [7:0] seed;
        step(1, 0, 8'h00, 0);
        step(1, 0, 8'h00, 0);
        // R1: reset state
        chk(empty && !full && !rd_valid && !wr_ack && !overflow && !underflow
            && wr_count == 0 && rd_count == 0, "R1 reset state", int'(empty), 1);

        // R3: fall-through of the first byte
        step(0, 1, 8'hA5, 0);
        chk(rd_valid && rd_data == 8'hA5, "R3 first byte visible", int'(rd_data), 8'hA5);
        // R9 / R10: read on a one-entry queue, then read on empty with a write
        step(0, 0, 8'h00, 1);
        step(0, 0, 8'h00, 1);
        chk(underflow == 1'b1, "R9 underflow pulse", int'(underflow), 1);
        step(0, 1, 8'h3C, 1);
        chk(underflow && wr_ack && rd_data == 8'h3C, "R10 empty rd+wr", int'(rd_data), 8'h3C);
        step(0, 0, 8'h00, 1);

        // R2 / R5 / R6 / R8: fill to 32, then overflow
        for (int i = 0; i < 32; i++) step(0, 1, 8'(i * 7 + 1), 0);
        chk(full && wr_count == 0, "R5 full count wraps", int'(wr_count), 0);
        step(0, 1, 8'hEE, 0);
        chk(overflow && !wr_ack, "R8 overflow pulse", int'(overflow), 1);
        step(0, 1, 8'hEF, 0);
        // R10: full with simultaneous read and write
        step(0, 1, 8'hDD, 1);
        chk(overflow && almost_full, "R10 full rd+wr rejects write", int'(overflow), 1);
        // R10: mid-level simultaneous read and write keep occupancy
        for (int i = 0; i < 6; i++) step(0, 1, 8'(8'h80 + i), 1);
        chk(rd_count == 31, "R10 steady occupancy", int'(rd_count), 31);
        // R4 / R2: drain fully
        for (int i = 0; i < 34; i++) step(0, 0, 8'h00, 1);
        chk(empty, "R2 drained", int'(empty), 1);

        // Mixed traffic
        seed = 8'h5B;
        for (int i = 0; i < 2000; i++) begin
            bit we, re;
            seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
            we = (i % 300 < 150) ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
            re = (i % 300 < 150) ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
            step(0, we, seed, re);
        end

        // R1: reset from a non-empty state
        for (int i = 0; i < 5; i++) step(0, 1, 8'(i), 0);
        step(1, 1, 8'h11, 1);
        chk(empty && rd_count == 0, "R1 mid-run reset", int'(rd_count), 0);
        step(0, 0, 8'h00, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule